// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two unsigned WIDTH-bit operands and returns their 2·WIDTH-bit product after WIDTH clock steps. It has one WIDTH-bit adder, used once per step. The product is built in place inside a single register made of a one-bit carry, a WIDTH-bit accumulator and a WIDTH-bit multiplier register. A separate register holds the multiplicand. Each step looks at the lowest bit of the multiplier register. If that bit is set, the step adds the multiplicand into the accumulator. The whole carry:accumulator:multiplier register then moves one place to the right. The product bits enter from the top as the used multiplier bits drop out at the bottom.

A one-cycle start request loads the operands. The block then shows busy for WIDTH cycles and raises done for one cycle as the last step completes. At that point the upper half of the product is in the accumulator and the lower half is in the multiplier register. These two registers drive the two product outputs directly. The outputs therefore show the running partial product while busy, and they hold the final result until the next accepted start.

Top module: `shiftadd_mult`

## Requirements
- R1: While rst_n is low at a clock edge, all registers clear. After that edge busy_o=0, done_o=0, prod_hi_o=0 and prod_lo_o=0. This holds whether or not an operation was in progress.
- R2: A start_i high at an edge where busy_o is low is accepted. busy_o is high from the next cycle on for exactly WIDTH cycles.
- R3: done_o is high for exactly one cycle, in the first cycle after busy_o falls. In that cycle {prod_hi_o, prod_lo_o} equals the unsigned product of the captured multiplicand and multiplier.
- R4: prod_hi_o carries product bits [2·WIDTH-1:WIDTH] and prod_lo_o carries bits [WIDTH-1:0].
- R5: A start_i while busy_o is high is ignored. The operands are not recaptured, the result is the product of the first operands, and the busy length stays WIDTH.
- R6: When no start is accepted, prod_hi_o, prod_lo_o, busy_o and done_o stay unchanged after done_o, whatever the operand inputs do.
- R7: During an operation, {prod_hi_o, prod_lo_o} shows the running register after each step. If its bit 0 was 1, the next value is ({0, prod_hi_o} + multiplicand, prod_lo_o) shifted right by one. Otherwise it is the old value shifted right by one. For WIDTH=4, 1111 × 0101 gives 1001_0110 after step 3 and 0100_1011 after step 4.
- R8: The corner operands give exact results. Any operand of zero gives 0. The all-ones product uses the carry bit: for WIDTH=8, 255 × 255 gives high 8'hFE and low 8'h01.
- R9: A start_i in the cycle where done_o is high is accepted. A new operation begins with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, honoured only while idle |
| mcand_i | input | WIDTH | Multiplicand, captured on an accepted start |
| mplier_i | input | WIDTH | Multiplier, captured on an accepted start |
| busy_o | output | 1 | High while steps are running |
| done_o | output | 1 | One-cycle pulse when the last step completes |
| prod_hi_o | output | WIDTH | Upper half of the product (accumulator) |
| prod_lo_o | output | WIDTH | Lower half of the product (multiplier register) |

## Verification
The properties place no constraint on start_i or on the operand inputs. They may take any value in any cycle, so the checks on ignored starts and on output stability cover every input value. The properties do assume a synchronous reset that is sampled at a clock edge, and each property is re-armed from the reset state. The bench changes inputs only on falling edges. It raises start_i in idle cycles, in mid-operation cycles and in the done cycle, and it changes the operand inputs while idle and while busy. This way every accepted-start and ignored-start path is reached.

// File: rtl/shiftadd_pkg.sv
package shiftadd_pkg;
  typedef enum logic {
    SAM_IDLE = 1'b0,
    SAM_RUN  = 1'b1
  } sam_state_e;
endpackage

// File: rtl/sam_adder.sv
module sam_adder #(
  parameter int WIDTH = 8
) (
  input  logic             hi_bit_i,
  input  logic [WIDTH-1:0] acc_i,
  input  logic [WIDTH-1:0] mdr_i,
  input  logic             add_en_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  localparam int EW = WIDTH + 1;

  function automatic logic [EW-1:0] cond_add(input logic hb, input logic [WIDTH-1:0] a,
                                             input logic [WIDTH-1:0] m, input logic en);
    logic [WIDTH-1:0] addend;
    addend = en ? m : '0;
    return {hb, a} + {1'b0, addend};
  endfunction

  logic [EW-1:0] total_w;
  assign total_w = cond_add(hi_bit_i, acc_i, mdr_i, add_en_i);
  assign sum_o   = total_w[WIDTH-1:0];
  assign cout_o  = total_w[EW-1];
endmodule

// File: rtl/sam_ctrl.sv
module sam_ctrl
  import shiftadd_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] STEPS = CW'(WIDTH);
  localparam logic [CW-1:0] LAST  = CW'(1);

  sam_state_e       state_q;
  logic [CW-1:0]    left_q;
  logic             done_q;

  assign busy_o = (state_q == SAM_RUN);
  assign load_o = start_i && !busy_o;
  assign step_o = busy_o;
  assign done_o = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SAM_IDLE;
      left_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        SAM_IDLE: begin
          if (start_i) begin
            state_q <= SAM_RUN;
            left_q  <= STEPS;
          end
        end
        SAM_RUN: begin
          left_q <= left_q - LAST;
          if (left_q == LAST) begin
            state_q <= SAM_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= SAM_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sam_shreg.sv
module sam_shreg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [WIDTH-1:0] mcand_i,
  input  logic [WIDTH-1:0] mplier_i,
  input  logic [WIDTH-1:0] sum_i,
  input  logic             cout_i,
  output logic             carry_o,
  output logic [WIDTH-1:0] acc_o,
  output logic [WIDTH-1:0] mq_o,
  output logic [WIDTH-1:0] mdr_o
);
  localparam int RW = 2 * WIDTH + 1;

  function automatic logic [RW-1:0] shift_one(input logic [RW-1:0] v);
    return {1'b0, v[RW-1:1]};
  endfunction

  logic [RW-1:0] next_w;
  assign next_w = shift_one({cout_i, sum_i, mq_o});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      carry_o <= 1'b0;
      acc_o   <= '0;
      mq_o    <= '0;
      mdr_o   <= '0;
    end else if (load_i) begin
      carry_o <= 1'b0;
      acc_o   <= '0;
      mq_o    <= mplier_i;
      mdr_o   <= mcand_i;
    end else if (step_i) begin
      {carry_o, acc_o, mq_o} <= next_w;
    end
  end
endmodule

// File: rtl/shiftadd_mult.sv
module shiftadd_mult #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [WIDTH-1:0] mcand_i,
  input  logic [WIDTH-1:0] mplier_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] prod_hi_o,
  output logic [WIDTH-1:0] prod_lo_o
);
  logic             load_w, step_w;
  logic             carry_q;
  logic [WIDTH-1:0] acc_q, mq_q, mdr_q;
  logic [WIDTH-1:0] sum_w;
  logic             cout_w;
  logic             step_add_w;

  assign step_add_w = step_w && mq_q[0];

  sam_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .load_o(load_w), .step_o(step_w), .busy_o(busy_o), .done_o(done_o)
  );

  sam_adder #(.WIDTH(WIDTH)) u_add (
    .hi_bit_i(carry_q), .acc_i(acc_q), .mdr_i(mdr_q), .add_en_i(step_add_w),
    .sum_o(sum_w), .cout_o(cout_w)
  );

  sam_shreg #(.WIDTH(WIDTH)) u_reg (
    .clk(clk), .rst_n(rst_n), .load_i(load_w), .step_i(step_w),
    .mcand_i(mcand_i), .mplier_i(mplier_i), .sum_i(sum_w), .cout_i(cout_w),
    .carry_o(carry_q), .acc_o(acc_q), .mq_o(mq_q), .mdr_o(mdr_q)
  );

  assign prod_hi_o = acc_q;
  assign prod_lo_o = mq_q;
endmodule

// File: rtl/shiftadd_mult_chk.sv
module shiftadd_mult_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [WIDTH-1:0] prod_hi_o,
  input logic [WIDTH-1:0] prod_lo_o,
  input logic [WIDTH-1:0] mdr_q
);
  localparam int RW = 2 * WIDTH + 1;
  localparam int KW = $clog2(WIDTH + 1) + 1;

  logic [RW-1:0] nxt_add_w, nxt_shift_w;
  logic [WIDTH:0] hi_sum_w;
  assign hi_sum_w    = {1'b0, prod_hi_o} + {1'b0, mdr_q};
  assign nxt_add_w   = {hi_sum_w, prod_lo_o} >> 1;
  assign nxt_shift_w = {1'b0, prod_hi_o, prod_lo_o} >> 1;

  logic [KW-1:0] busy_cnt_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                busy_cnt_q <= '0;
    else if (start_i && !busy_o) busy_cnt_q <= '0;
    else if (busy_o)           busy_cnt_q <= busy_cnt_q + KW'(1);
  end

  a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_o |=> busy_o);
  a_r2_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_cnt_q == KW'(WIDTH));
  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r3_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  a_r5_ignore_start: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(mdr_q));
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && !start_i |=> $stable(prod_hi_o) && $stable(prod_lo_o) && !busy_o);
  a_r7_add_step: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && prod_lo_o[0] |=> {1'b0, prod_hi_o, prod_lo_o} == $past(nxt_add_w));
  a_r7_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !prod_lo_o[0] |=> {1'b0, prod_hi_o, prod_lo_o} == $past(nxt_shift_w));
endmodule

bind shiftadd_mult shiftadd_mult_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
  .prod_hi_o(prod_hi_o), .prod_lo_o(prod_lo_o), .mdr_q(mdr_q)
);

// File: tb/shiftadd_mult_tb.sv
module shiftadd_mult_tb;
  localparam int W = 8;
  localparam int NV = 10;
  localparam logic [2*W-1:0] VEC [NV] = '{
    {8'd0, 8'd0}, {8'd255, 8'd255}, {8'd0, 8'd200}, {8'd1, 8'd1}, {8'd15, 8'd5},
    {8'd128, 8'd2}, {8'd170, 8'd85}, {8'd13, 8'd11}, {8'd255, 8'd1}, {8'd1, 8'd255}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [W-1:0] mc = '0, mp = '0, hi, lo;
  logic busy, done;
  logic start4 = 1'b0;
  logic [3:0] mc4 = '0, mp4 = '0, hi4, lo4;
  logic busy4, done4;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  shiftadd_mult #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .mcand_i(mc), .mplier_i(mp),
    .busy_o(busy), .done_o(done), .prod_hi_o(hi), .prod_lo_o(lo));

  shiftadd_mult #(.WIDTH(4)) u_dut_n4 (
    .clk(clk), .rst_n(rst_n), .start_i(start4), .mcand_i(mc4), .mplier_i(mp4),
    .busy_o(busy4), .done_o(done4), .prod_hi_o(hi4), .prod_lo_o(lo4));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Caller is at a falling edge; returns at the falling edge where busy is low.
  task automatic run8(input logic [W-1:0] a, input logic [W-1:0] b, output int cyc);
    start = 1'b1; mc = a; mp = b;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (busy && cyc < 100) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(1_990_000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    int cyc;
    logic [2*W-1:0] exp_p;
    logic [8:0] model;
    repeat (3) @(negedge clk);
    chk(!busy && !done, "R1 reset flags", {busy, done}, 0);
    chk({hi, lo} == 0, "R1 reset product", {hi, lo}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      exp_p = VEC[i][2*W-1:W] * VEC[i][W-1:0];
      run8(VEC[i][2*W-1:W], VEC[i][W-1:0], cyc);
      chk(cyc == W, "R2 busy length", cyc, W);
      chk(done, "R3 done pulse", done, 1);
      chk({hi, lo} == exp_p, "R3 product", {hi, lo}, exp_p);
      chk(hi == exp_p[2*W-1:W] && lo == exp_p[W-1:0], "R4 halves", hi, exp_p[2*W-1:W]);
      @(negedge clk);
      chk(!done, "R3 done one cycle", done, 0);
    end

    // R8 corners
    run8(8'd255, 8'd255, cyc);
    chk(hi == 8'hFE && lo == 8'h01, "R8 all ones", {hi, lo}, 16'hFE01);
    @(negedge clk);
    run8(8'd0, 8'd77, cyc);
    chk({hi, lo} == 0, "R8 zero multiplicand", {hi, lo}, 0);
    @(negedge clk);

    // R5 start while busy
    start = 1'b1; mc = 8'd200; mp = 8'd3;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (busy && cyc < 100) begin
      cyc++;
      if (cyc == 2) begin start = 1'b1; mc = 8'd7; mp = 8'd9; end
      if (cyc == 3) start = 1'b0;
      @(negedge clk);
    end
    chk(cyc == W, "R5 busy length kept", cyc, W);
    chk({hi, lo} == 16'd600, "R5 first operands kept", {hi, lo}, 600);

    // R6 hold after done with moving inputs
    exp_p = {hi, lo};
    mc = 8'h5A; mp = 8'hC3;
    repeat (4) @(negedge clk);
    chk({hi, lo} == exp_p, "R6 product held", {hi, lo}, exp_p);
    chk(!busy && !done, "R6 idle held", {busy, done}, 0);

    // R9 back-to-back
    run8(8'd12, 8'd12, cyc);
    chk(done, "R9 first done", done, 1);
    run8(8'd200, 8'd201, cyc);
    chk(cyc == W, "R9 second busy length", cyc, W);
    chk({hi, lo} == 16'd40200, "R9 second product", {hi, lo}, 40200);
    @(negedge clk);

    // R7 step trace at WIDTH=4, 1111 x 0101
    start4 = 1'b1; mc4 = 4'hF; mp4 = 4'h5;
    @(negedge clk);
    start4 = 1'b0;
    model = {5'd0, 4'h5};
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      if (model[0]) model = model + {1'b0, 4'hF, 4'h0};
      model = model >> 1;
      chk({hi4, lo4} == model[7:0], "R7 step value", {hi4, lo4}, model[7:0]);
      if (k == 3) chk({hi4, lo4} == 8'h96, "R7 after step 3", {hi4, lo4}, 8'h96);
    end
    chk({hi4, lo4} == 8'h4B && done4, "R7 final", {hi4, lo4}, 8'h4B);

    // R1 reset mid-operation
    @(negedge clk);
    start = 1'b1; mc = 8'd99; mp = 8'd99;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!busy && !done && {hi, lo} == 0, "R1 mid-op reset", {busy, hi, lo}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule